// File: doc/BRIEF.md
# Constant-Power Oscillator Farm Controller

This block closes a feedback loop that holds a device's total supply current close to constant. An on-chip delay sensor reports a code from time to time. A larger code means a cell has become slower. A slower cell means the supply has sagged, which in turn means the rest of the chip is drawing more current. The controller answers by switching dummy oscillator loads off, and it switches them back on when the delay shortens again. It reacts only to measurements and never predicts activity.

The loads sit in equal farms, four of 128 by default. Every step adds or removes exactly one oscillator in each farm, so all farms always carry the same number of active loads. Within a farm the loads switch in a fixed thermometer order. The setpoint, the dead band around it and the minimum number of samples between steps all come from input ports. Regulation starts only once the enable input is raised. Until then every load stays on, as it is after reset.

Top module: `cpf_farm_ctrl`

## Requirements
- R1: During and right after reset the per-farm level is 128, all 512 enable bits are 1 and `pinned_o` is 1.
- R2: While `reg_en_i` is 0, or when `code_vld_i` is 0, the level does not change.
- R3: An accepted sample whose code is above setpoint plus band lowers the level by one, unless the level is already 0.
- R4: An accepted sample whose code is below setpoint minus band raises the level by one, unless the level is already 128.
- R5: A code inside the band, with both edges counted as inside, leaves the level unchanged. This holds even when setpoint plus band exceeds the code range.
- R6: Bit `f*128+i` of `osc_en_o` is 1 exactly when `i` is less than the level, and this is the same for every farm `f`.
- R7: The level saturates at 0 and at 128 and never wraps.
- R8: `pinned_o` is 1 exactly when the level is 0 or 128.
- R9: A step happens only if the number of accepted samples since the last step, including the present one, has reached `pace_i`. A `pace_i` of 0 behaves like 1. The count restarts after each step and while `reg_en_i` is 0, and samples that cause no step still add to it.
- R10: The level changes by at most one per cycle, and a change caused by a sample is visible the cycle after the clock edge that takes that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Regulation enable |
| code_vld_i | input | 1 | Sensor code strobe |
| code_i | input | 8 | Delay code from the sensor |
| setpoint_i | input | 8 | Target delay code |
| band_i | input | 8 | Half-width of the dead band |
| pace_i | input | 8 | Minimum number of accepted samples per step |
| osc_en_o | output | 512 | Oscillator enables, farm-major, thermometer within each farm |
| level_o | output | 8 | Enabled oscillators per farm, 0 to 128 |
| pinned_o | output | 1 | Level sits at a limit |

## Verification
The loop is driven first by steady codes above the band, then by steady codes below it. These two runs show that the level moves in the right direction and stops at both limits. Codes placed exactly on the band edges, together with a setpoint and band whose sum overflows eight bits, separate an inclusive dead band from an exclusive one and catch comparisons that wrap. Runs with pace values of 0, 1 and 4, with gaps in the strobe and the enable toggled, show whether the sample counter restarts at the right moments. A long stretch of random codes around the setpoint is then checked against a behavioural model on every clock.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

   typedef enum logic [1:0] {
      CPF_HOLD = 2'd0,
      CPF_SHED = 2'd1,
      CPF_ADD  = 2'd2
   } cpf_dir_e;

endpackage

// File: rtl/cpf_window.sv
// Dead-band comparator: classifies one delay code against setpoint +/- band.
module cpf_window
   import cpf_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [CODE_W-1:0] setpoint_i,
   input  logic [CODE_W-1:0] band_i,
   output cpf_dir_e          dir_o
);

   localparam int XW = CODE_W + 1;

   logic [XW-1:0] code_x;
   logic [XW-1:0] upper_x;
   logic [XW-1:0] code_plus_band_x;
   logic [XW-1:0] sp_x;

   // One extra bit keeps the sums from wrapping.
   assign code_x           = {1'b0, code_i};
   assign sp_x             = {1'b0, setpoint_i};
   assign upper_x          = sp_x + {1'b0, band_i};
   assign code_plus_band_x = code_x + {1'b0, band_i};

   always_comb begin
      if (code_x > upper_x) begin
         dir_o = CPF_SHED;
      end else if (code_plus_band_x < sp_x) begin
         dir_o = CPF_ADD;
      end else begin
         dir_o = CPF_HOLD;
      end
   end

endmodule

// File: rtl/cpf_pacer.sv
// Counts accepted samples since the last step and gates the next one.
module cpf_pacer #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             sample_i,
   input  logic             step_i,
   input  logic [DIV_W-1:0] pace_i,
   output logic             ready_o
);

   localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cnt_inc;

   // Saturating increment; a pace of zero is met by any count.
   assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
   assign ready_o = (cnt_inc >= pace_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i || step_i) begin
         cnt_q <= '0;
      end else if (sample_i) begin
         cnt_q <= cnt_inc;
      end
   end

endmodule

// File: rtl/cpf_level.sv
// Saturating per-farm level counter.
module cpf_level
   import cpf_pkg::*;
#(
   parameter int FARM_SIZE = 128,
   parameter int CNT_W     = $clog2(FARM_SIZE + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  cpf_dir_e         dir_i,
   output logic [CNT_W-1:0] level_o,
   output logic             at_floor_o,
   output logic             at_ceil_o
);

   localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(FARM_SIZE);

   logic [CNT_W-1:0] level_q;

   assign at_floor_o = (level_q == '0);
   assign at_ceil_o  = (level_q == LVL_MAX);
   assign level_o    = level_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         level_q <= LVL_MAX;
      end else if (step_i) begin
         unique case (dir_i)
            CPF_SHED: if (!at_floor_o) level_q <= level_q - 1'b1;
            CPF_ADD:  if (!at_ceil_o)  level_q <= level_q + 1'b1;
            default:  level_q <= level_q;
         endcase
      end
   end

endmodule

// File: rtl/cpf_therm.sv
// Level-to-thermometer decoder, replicated per farm, optional output flop.
module cpf_therm #(
   parameter int FARM_SIZE = 128,
   parameter int NUM_FARMS = 4,
   parameter bit OUT_REG   = 1'b0,
   parameter int CNT_W     = $clog2(FARM_SIZE + 1)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [CNT_W-1:0]               level_i,
   output logic [NUM_FARMS*FARM_SIZE-1:0] en_o
);

   localparam int TOTAL = NUM_FARMS * FARM_SIZE;

   logic [FARM_SIZE-1:0] farm_pat;
   logic [TOTAL-1:0]     all_pat;

   for (genvar i = 0; i < FARM_SIZE; i++) begin : g_bit
      assign farm_pat[i] = (level_i > CNT_W'(i));
   end

   for (genvar f = 0; f < NUM_FARMS; f++) begin : g_farm
      assign all_pat[f*FARM_SIZE +: FARM_SIZE] = farm_pat;
   end

   if (OUT_REG) begin : g_flop
      logic [TOTAL-1:0] en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_q <= '1;
         end else begin
            en_q <= all_pat;
         end
      end
      assign en_o = en_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign en_o = all_pat;
   end

endmodule

// File: rtl/cpf_farm_ctrl.sv
// Constant-power oscillator farm controller (top).
module cpf_farm_ctrl
   import cpf_pkg::*;
#(
   parameter int NUM_FARMS = 4,
   parameter int FARM_SIZE = 128,
   parameter int CODE_W    = 8,
   parameter int DIV_W     = 8,
   parameter bit OUT_REG   = 1'b0,
   parameter int CNT_W     = $clog2(FARM_SIZE + 1),
   parameter int TOTAL     = NUM_FARMS * FARM_SIZE
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_en_i,
   input  logic              code_vld_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [CODE_W-1:0] setpoint_i,
   input  logic [CODE_W-1:0] band_i,
   input  logic [DIV_W-1:0]  pace_i,
   output logic [TOTAL-1:0]  osc_en_o,
   output logic [CNT_W-1:0]  level_o,
   output logic              pinned_o
);

   // Elaboration-time parameter checks
   if (NUM_FARMS < 1) begin : g_bad_farms
      $error("cpf_farm_ctrl: NUM_FARMS must be at least 1");
   end
   if (FARM_SIZE < 2) begin : g_bad_size
      $error("cpf_farm_ctrl: FARM_SIZE must be at least 2");
   end
   if (CODE_W < 2) begin : g_bad_code
      $error("cpf_farm_ctrl: CODE_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("cpf_farm_ctrl: DIV_W must be at least 1");
   end
   if (CNT_W < $clog2(FARM_SIZE + 1)) begin : g_bad_cnt
      $error("cpf_farm_ctrl: CNT_W too narrow for FARM_SIZE");
   end
   if (TOTAL != NUM_FARMS * FARM_SIZE) begin : g_bad_total
      $error("cpf_farm_ctrl: TOTAL must equal NUM_FARMS*FARM_SIZE");
   end

   cpf_dir_e dir;
   logic     sample;
   logic     ready;
   logic     at_floor;
   logic     at_ceil;
   logic     room;
   logic     go;

   assign sample = reg_en_i & code_vld_i;
   assign room   = ((dir == CPF_SHED) && !at_floor) ||
                   ((dir == CPF_ADD)  && !at_ceil);
   assign go     = sample & ready & room;

   cpf_window #(
      .CODE_W(CODE_W)
   ) u_window (
      .code_i    (code_i),
      .setpoint_i(setpoint_i),
      .band_i    (band_i),
      .dir_o     (dir)
   );

   cpf_pacer #(
      .DIV_W(DIV_W)
   ) u_pacer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (!reg_en_i),
      .sample_i(sample),
      .step_i  (go),
      .pace_i  (pace_i),
      .ready_o (ready)
   );

   cpf_level #(
      .FARM_SIZE(FARM_SIZE),
      .CNT_W    (CNT_W)
   ) u_level (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (go),
      .dir_i     (dir),
      .level_o   (level_o),
      .at_floor_o(at_floor),
      .at_ceil_o (at_ceil)
   );

   cpf_therm #(
      .FARM_SIZE(FARM_SIZE),
      .NUM_FARMS(NUM_FARMS),
      .OUT_REG  (OUT_REG),
      .CNT_W    (CNT_W)
   ) u_therm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .level_i(level_o),
      .en_o   (osc_en_o)
   );

   assign pinned_o = at_floor | at_ceil;

endmodule

// File: rtl/cpf_farm_ctrl_chk.sv
// Property checker bound to the controller top.
module cpf_farm_ctrl_chk #(
   parameter int NUM_FARMS = 4,
   parameter int FARM_SIZE = 128,
   parameter int CODE_W    = 8,
   parameter int DIV_W     = 8,
   parameter bit OUT_REG   = 1'b0,
   parameter int CNT_W     = $clog2(FARM_SIZE + 1),
   parameter int TOTAL     = NUM_FARMS * FARM_SIZE
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              reg_en_i,
   input logic              code_vld_i,
   input logic [CODE_W-1:0] code_i,
   input logic [CODE_W-1:0] setpoint_i,
   input logic [CODE_W-1:0] band_i,
   input logic [DIV_W-1:0]  pace_i,
   input logic [TOTAL-1:0]  osc_en_o,
   input logic [CNT_W-1:0]  level_o,
   input logic              pinned_o
);

   logic [CODE_W:0] hi_x;
   logic [CODE_W:0] cb_x;
   logic            smp;
   logic            pace_unused;

   assign hi_x = {1'b0, setpoint_i} + {1'b0, band_i};
   assign cb_x = {1'b0, code_i} + {1'b0, band_i};
   assign smp  = reg_en_i & code_vld_i;
   assign pace_unused = ^pace_i;

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(level_o) <= FARM_SIZE); // R7

   AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_o != $past(level_o)) |->
         ((level_o == $past(level_o) + 1'b1) || (level_o == $past(level_o) - 1'b1))); // R10

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !smp |=> $stable(level_o)); // R2

   AST_SHED_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp && ({1'b0, code_i} > hi_x)) |=> (level_o <= $past(level_o))); // R3

   AST_ADD_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp && (cb_x < {1'b0, setpoint_i})) |=> (level_o >= $past(level_o))); // R4

   AST_BAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (({1'b0, code_i} <= hi_x) && (cb_x >= {1'b0, setpoint_i})) |=> $stable(level_o)); // R5

   if (!OUT_REG) begin : g_mask_chk
      for (genvar f = 0; f < NUM_FARMS; f++) begin : g_farm
         AST_FARM_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $countones(osc_en_o[f*FARM_SIZE +: FARM_SIZE]) == int'(level_o)); // R6
      end
      AST_PIN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pinned_o == (($countones(osc_en_o[FARM_SIZE-1:0]) == 0) ||
                      ($countones(osc_en_o[FARM_SIZE-1:0]) == FARM_SIZE))); // R8
   end

endmodule

bind cpf_farm_ctrl cpf_farm_ctrl_chk #(
   .NUM_FARMS(NUM_FARMS),
   .FARM_SIZE(FARM_SIZE),
   .CODE_W   (CODE_W),
   .DIV_W    (DIV_W),
   .OUT_REG  (OUT_REG),
   .CNT_W    (CNT_W),
   .TOTAL    (TOTAL)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .reg_en_i  (reg_en_i),
   .code_vld_i(code_vld_i),
   .code_i    (code_i),
   .setpoint_i(setpoint_i),
   .band_i    (band_i),
   .pace_i    (pace_i),
   .osc_en_o  (osc_en_o),
   .level_o   (level_o),
   .pinned_o  (pinned_o)
);

// File: tb/cpf_farm_ctrl_tb_top.sv
`timescale 1ns/1ps
module cpf_farm_ctrl_tb_top;

   localparam int NF  = 4;
   localparam int FS  = 128;
   localparam int TOT = NF * FS;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_en = 1'b0;
   logic           vld = 1'b0;
   logic [7:0]     code = '0;
   logic [7:0]     setpoint = 8'd100;
   logic [7:0]     band = 8'd5;
   logic [7:0]     pace = 8'd1;
   logic [TOT-1:0] osc_en;
   logic [7:0]     level;
   logic           pinned;

   int n_chk = 0;
   int n_fail = 0;
   int m_level = FS;
   int m_cnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cpf_farm_ctrl dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .reg_en_i  (reg_en),
      .code_vld_i(vld),
      .code_i    (code),
      .setpoint_i(setpoint),
      .band_i    (band),
      .pace_i    (pace),
      .osc_en_o  (osc_en),
      .level_o   (level),
      .pinned_o  (pinned)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [TOT-1:0] exp_mask(input int lvl);
      logic [TOT-1:0] m;
      for (int f = 0; f < NF; f++)
         for (int i = 0; i < FS; i++)
            m[f*FS+i] = (i < lvl);
      return m;
   endfunction

   // Reference model for one clock edge using the currently driven inputs.
   task automatic model_step();
      int nxt, up, cb;
      int dir;
      if (!reg_en) begin
         m_cnt = 0;
      end else if (vld) begin
         nxt = (m_cnt == 255) ? 255 : m_cnt + 1;
         up  = int'(setpoint) + int'(band);
         cb  = int'(code) + int'(band);
         dir = (int'(code) > up) ? -1 : ((cb < int'(setpoint)) ? 1 : 0);
         if (nxt >= int'(pace) && ((dir < 0 && m_level > 0) || (dir > 0 && m_level < FS))) begin
            m_level = m_level + dir;
            m_cnt = 0;
         end else begin
            m_cnt = nxt;
         end
      end
   endtask

   task automatic compare();
      logic [TOT-1:0] em;
      em = exp_mask(m_level);
      chk(int'(level) == m_level, "R10 level", level, m_level);
      chk(pinned == (m_level == 0 || m_level == FS), "R8 pinned", pinned, (m_level == 0 || m_level == FS));
      chk(osc_en === em, "R6 mask", $countones(osc_en), $countones(em));
   endtask

   task automatic cyc(input logic en, input logic v, input logic [7:0] c);
      reg_en = en;
      vld = v;
      code = c;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic run(input logic en, input logic [7:0] c, input int n);
      for (int k = 0; k < n; k++) cyc(en, 1'b1, c);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(int'(level) == FS, "R1 level", level, FS);
      chk(osc_en === {TOT{1'b1}}, "R1 mask", $countones(osc_en), TOT);
      chk(pinned == 1'b1, "R1 pinned", pinned, 1);
      rst_n = 1'b1;
      @(negedge clk);
      compare();

      // R2: disabled, samples ignored
      run(1'b0, 8'd200, 6);
      run(1'b0, 8'd0, 6);
      chk(int'(level) == FS, "R2 held while disabled", level, FS);
      // R2: enabled but no strobe
      for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0, 8'd250);
      chk(int'(level) == FS, "R2 held without strobe", level, FS);

      // R3: above band sheds one per sample at pace 1
      run(1'b1, 8'd110, 10);
      chk(int'(level) == FS - 10, "R3 shed", level, FS - 10);
      // R5: band edges are inside
      run(1'b1, 8'd105, 4);
      run(1'b1, 8'd95, 4);
      chk(int'(level) == FS - 10, "R5 band edges hold", level, FS - 10);
      // R3: first code just above upper edge
      run(1'b1, 8'd106, 1);
      chk(int'(level) == FS - 11, "R3 upper edge+1", level, FS - 11);
      // R4: first code just below lower edge
      run(1'b1, 8'd94, 4);
      chk(int'(level) == FS - 7, "R4 add", level, FS - 7);

      // R9: pace 4
      pace = 8'd4;
      run(1'b1, 8'd120, 12);
      chk(int'(level) == FS - 10, "R9 pace 4", level, FS - 10);
      // R9: held samples count toward pace
      run(1'b1, 8'd100, 3);
      run(1'b1, 8'd120, 1);
      chk(int'(level) == FS - 11, "R9 hold samples counted", level, FS - 11);
      // R9: disable restarts the count
      run(1'b1, 8'd120, 2);
      cyc(1'b0, 1'b0, 8'd0);
      run(1'b1, 8'd120, 3);
      chk(int'(level) == FS - 11, "R9 restart on disable", level, FS - 11);
      run(1'b1, 8'd120, 1);
      chk(int'(level) == FS - 12, "R9 step after restart", level, FS - 12);
      // R9: pace 0 acts as 1
      pace = 8'd0;
      run(1'b1, 8'd120, 5);
      chk(int'(level) == FS - 17, "R9 pace 0", level, FS - 17);

      // R7/R8: floor saturation
      pace = 8'd1;
      run(1'b1, 8'd255, 130);
      chk(int'(level) == 0, "R7 floor", level, 0);
      chk(pinned == 1'b1, "R8 pinned at floor", pinned, 1);
      chk(osc_en === '0, "R6 all off", $countones(osc_en), 0);
      // R7: ceiling saturation
      run(1'b1, 8'd0, 140);
      chk(int'(level) == FS, "R7 ceiling", level, FS);
      chk(pinned == 1'b1, "R8 pinned at ceiling", pinned, 1);

      // R5: band sum beyond code range, never sheds
      setpoint = 8'd250;
      band = 8'd20;
      run(1'b1, 8'd255, 8);
      chk(int'(level) == FS, "R5 wide band hold", level, FS);
      // R4/R5: band 0 around setpoint 0 holds at 0
      setpoint = 8'd0;
      band = 8'd0;
      run(1'b1, 8'd1, 3);
      run(1'b1, 8'd0, 5);
      chk(int'(level) == FS - 3, "R5 zero band hold", level, FS - 3);

      // Random workout against the model
      setpoint = 8'd128;
      band = 8'd3;
      for (int k = 0; k < 3000; k++) begin
         if (k % 500 == 0) pace = 8'($urandom_range(0, 3));
         cyc(($urandom_range(0, 19) != 0), ($urandom_range(0, 3) != 0),
             8'(128 + $signed($urandom_range(0, 20)) - 10));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule